// File: doc/BRIEF.md
# 32-Line Prioritised Interrupt Handler

This block gathers 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each line is configured separately. The configuration chooses whether the line is edge sensed or level sensed, sets a 5-bit priority, and selects which of the two outputs the line reports to. Requests are latched into a pending word. A per-line mask hides pending lines from arbitration.

Each output has an agreement flag. When the flag is armed and at least one unmasked pending line is steered to that output, the output rises and the flag disarms. At the same clock edge the number of the winning line is captured into a source-code register. Software reads that register to learn which line to service. The read also acknowledges an edge-sensed line. The output stays high until software writes the matching control bit. That write drops the output and re-arms the flag, so a new arbitration takes place on the following cycle.

Software uses a 32-bit register port with separate read and write strobes. Only word-aligned addresses are decoded. Read data is registered and appears one cycle after the read strobe.

Top module: `intr_steer_ctrl`

## Requirements
- R1: After reset, the mask word (0x04) reads all ones and the pending word (0x00) reads zero. Every line configuration reads zero, which means edge sensed, priority 0 and steered to `irq_o`. Both outputs are low and both agreement flags are armed.
- R2: In edge mode (configuration bit 1 = 0), a line becomes pending at the clock edge that first samples its input high after it was sampled low. The line stays pending after the input falls.
- R3: In level mode (configuration bit 1 = 1), a line is pending while its input is sampled high. The pending bit clears at the edge that samples the input going low.
- R4: A write to 0x00 ANDs the pending word with the written data. Level-mode lines whose input is currently high keep their pending bit.
- R5: The configuration word for line n is at 0x1C + 4·n. Priority is in bits [6:2], sense mode in bit 1, and output steer in bit 0 (1 = `fiq_o`). This word reads back with all other bits zero. A write or read whose address bits [1:0] are not zero has no effect and returns zero.
- R6: Among the unmasked pending lines steered to an output, the line with the numerically lowest priority wins. On a tie, the higher line number wins. Lines steered to the other output do not take part.
- R7: An output rises one cycle after its flag is armed and a candidate exists. It then stays high until a write to control (0x18) sets bit 0 (for `irq_o`) or bit 1 (for `fiq_o`). That write lowers the output at the next edge and re-arms the flag.
- R8: A read of 0x10 (for `irq_o`) or 0x14 (for `fiq_o`) returns the line number captured when that output last rose. The read clears that line's pending bit if the line is edge sensed. A level-sensed line is left pending.
- R9: A write to 0x9C makes only the lowest set bit of the written data pending.
- R10: While a line is masked, it cannot raise an output. A write to the mask word (0x04) is used by arbitration from the next cycle onwards.
- R11: `rdata` presents the addressed register one cycle after `rd_en`. At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 32 | Interrupt request lines, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
The assertions assume that software does not issue a read and a write in the same cycle. They also assume that the software-trigger write is never combined with a request edge, or with a level line that was switched to level mode while already high. Either case would let more than one new pending bit appear in that cycle. The stimulus drives requests and bus strobes only on falling edges and uses at most one strobe per cycle. It leaves the request inputs unchanged on the cycle of every software-trigger write, and only reconfigures a line while its input is low. A behavioural model in the bench tracks every cycle, including same-cycle rises across several lines.

// File: rtl/intr_steer_ctrl.sv
module intr_steer_ctrl #(
  parameter int LINES  = 32,
  parameter int PRIO_W = 5,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam logic [AW-1:0] A_PEND    = AW'('h00);
  localparam logic [AW-1:0] A_MASK    = AW'('h04);
  localparam logic [AW-1:0] A_ICODE   = AW'('h10);
  localparam logic [AW-1:0] A_FCODE   = AW'('h14);
  localparam logic [AW-1:0] A_CTRL    = AW'('h18);
  localparam logic [AW-1:0] A_CFG0    = AW'('h1C);
  localparam logic [AW-1:0] A_CFG_END = AW'(28 + 4 * LINES);
  localparam logic [AW-1:0] A_SWSET   = AW'('h9C);

  logic [LINES-1:0]             pend_q, mask_q, lvl_q, steer_q, in_q;
  logic [LINES-1:0][PRIO_W-1:0] prio_q;
  logic [1:0]                   agr_q, out_q;
  logic [1:0][IDX_W-1:0]        code_q;
  logic [DW-1:0]                rdata_q;

  logic acc_ok, wr_ok, rd_ok, cfg_hit, ctrl_wr, ack_hit;
  logic [IDX_W-1:0] cfg_idx, ack_line;
  logic [DW-1:0]    sw_low, rd_val;
  logic [LINES-1:0] pend_nxt;
  logic [1:0][LINES-1:0]  cand;
  logic [1:0][IDX_W-1:0]  win;

  assign acc_ok   = (addr[1:0] == 2'b00);
  assign wr_ok    = wr_en & acc_ok;
  assign rd_ok    = rd_en & acc_ok;
  assign cfg_hit  = (addr >= A_CFG0) && (addr < A_CFG_END);
  assign cfg_idx  = IDX_W'((addr - A_CFG0) >> 2);
  assign ctrl_wr  = wr_ok && (addr == A_CTRL);
  assign ack_hit  = rd_ok && ((addr == A_ICODE) || (addr == A_FCODE));
  assign ack_line = (addr == A_FCODE) ? code_q[1] : code_q[0];
  assign sw_low   = wdata & (~wdata + 1'b1);

  assign cand[0] = pend_q & ~mask_q & ~steer_q;
  assign cand[1] = pend_q & ~mask_q &  steer_q;

  always_comb begin
    logic [PRIO_W-1:0] best;
    for (int p = 0; p < 2; p++) begin
      best   = '1;
      win[p] = '0;
      for (int i = 0; i < LINES; i++) begin
        if (cand[p][i] && (prio_q[i] <= best)) begin
          best   = prio_q[i];
          win[p] = IDX_W'(i);
        end
      end
    end
  end

  always_comb begin
    pend_nxt = pend_q | (~lvl_q & req_in & ~in_q) | (lvl_q & req_in);
    pend_nxt = pend_nxt & ~(lvl_q & in_q & ~req_in);
    if (wr_ok && (addr == A_SWSET)) pend_nxt = pend_nxt | sw_low[LINES-1:0];
    if (wr_ok && (addr == A_PEND))  pend_nxt = pend_nxt & (wdata[LINES-1:0] | (lvl_q & req_in));
    if (ack_hit && !lvl_q[ack_line]) pend_nxt[ack_line] = 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (acc_ok) begin
      if (cfg_hit) begin
        rd_val = DW'({prio_q[cfg_idx], lvl_q[cfg_idx], steer_q[cfg_idx]});
      end else begin
        case (addr)
          A_PEND:  rd_val = DW'(pend_q);
          A_MASK:  rd_val = DW'(mask_q);
          A_ICODE: rd_val = DW'(code_q[0]);
          A_FCODE: rd_val = DW'(code_q[1]);
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '1;
      lvl_q   <= '0;
      steer_q <= '0;
      in_q    <= '0;
      prio_q  <= '0;
      agr_q   <= 2'b11;
      out_q   <= 2'b00;
      code_q  <= '0;
      rdata_q <= '0;
    end else begin
      pend_q  <= pend_nxt;
      in_q    <= req_in;
      rdata_q <= rd_en ? rd_val : '0;
      if (wr_ok && (addr == A_MASK)) mask_q <= wdata[LINES-1:0];
      if (wr_ok && cfg_hit) begin
        prio_q[cfg_idx]  <= wdata[PRIO_W+1:2];
        lvl_q[cfg_idx]   <= wdata[1];
        steer_q[cfg_idx] <= wdata[0];
      end
      for (int p = 0; p < 2; p++) begin
        if (ctrl_wr && wdata[p]) begin
          out_q[p] <= 1'b0;
          agr_q[p] <= 1'b1;
        end else if (agr_q[p] && (|cand[p])) begin
          out_q[p]  <= 1'b1;
          agr_q[p]  <= 1'b0;
          code_q[p] <= win[p];
        end
      end
    end
  end

  assign rdata = rdata_q;
  assign irq_o = out_q[0];
  assign fiq_o = out_q[1];
endmodule

// File: rtl/intr_steer_chk.sv
module intr_steer_chk #(
  parameter int LINES = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [1:0]       ctrl_bits,
  input logic [LINES-1:0] req_in,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] lvl,
  input logic [LINES-1:0] steer,
  input logic [LINES-1:0] in_q,
  input logic             irq_o,
  input logic             fiq_o
);
  localparam logic [AW-1:0] C_CTRL  = AW'('h18);
  localparam logic [AW-1:0] C_SWSET = AW'('h9C);

  logic rearm_i, rearm_f, sw_quiet;
  assign rearm_i  = wr_en && (addr == C_CTRL) && ctrl_bits[0];
  assign rearm_f  = wr_en && (addr == C_CTRL) && ctrl_bits[1];
  assign sw_quiet = wr_en && (addr == C_SWSET) && (req_in == in_q) &&
                    ((lvl & req_in & ~pend) == '0);

  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rearm_i) |=> irq_o);
  a_r7_irq_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> !irq_o);
  a_r7_fiq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !rearm_f) |=> fiq_o);
  a_r7_fiq_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_f |=> !fiq_o);
  a_r10_fully_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask) && !irq_o && !fiq_o) |=> (!irq_o && !fiq_o));
  a_r6_irq_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(pend & ~mask & ~steer)));
  a_r6_fiq_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(|(pend & ~mask & steer)));
  a_r9_single_soft_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    sw_quiet |=> ($countones(pend & ~$past(pend)) <= 1));
endmodule

bind intr_steer_ctrl intr_steer_chk #(.LINES(LINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .ctrl_bits(wdata[1:0]),
  .req_in(req_in), .pend(pend_q), .mask(mask_q), .lvl(lvl_q), .steer(steer_q),
  .in_q(in_q), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/sim_intr_steer_ctrl.sv
`timescale 1ns/1ps
module sim_intr_steer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  intr_steer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // behavioural reference model
  bit [31:0] m_pend, m_mask, m_lvl, m_steer, m_in, m_rd;
  int        m_prio [32];
  bit        m_agr [2];
  bit        m_out [2];
  int        m_code [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_mask = '1; m_lvl = 0; m_steer = 0; m_in = 0; m_rd = 0;
      for (int i = 0; i < 32; i++) m_prio[i] = 0;
      for (int p = 0; p < 2; p++) begin m_agr[p] = 1; m_out[p] = 0; m_code[p] = 0; end
    end else begin
      bit [31:0] np, rv;
      int a;
      a  = int'(addr);
      rv = 0;
      if (a % 4 == 0) begin
        if (a >= 28 && a < 156)
          rv = (m_prio[(a-28)/4] << 2) | (m_lvl[(a-28)/4] << 1) | m_steer[(a-28)/4];
        else if (a == 0)  rv = m_pend;
        else if (a == 4)  rv = m_mask;
        else if (a == 16) rv = m_code[0];
        else if (a == 20) rv = m_code[1];
      end
      np = m_pend;
      for (int i = 0; i < 32; i++) begin
        if (m_lvl[i]) begin
          if (req_in[i]) np[i] = 1;
          else if (m_in[i]) np[i] = 0;
        end else if (req_in[i] && !m_in[i]) np[i] = 1;
      end
      if (wr_en && a == 156) begin
        for (int i = 0; i < 32; i++) if (wdata[i]) begin np[i] = 1; break; end
      end
      if (wr_en && a == 0) np = np & (wdata | (m_lvl & req_in));
      if (rd_en && (a == 16 || a == 20)) begin
        int ln;
        ln = m_code[a == 20 ? 1 : 0];
        if (!m_lvl[ln]) np[ln] = 0;
      end
      for (int p = 0; p < 2; p++) begin
        int best, w;
        bit any;
        best = 99; w = 0; any = 0;
        for (int i = 0; i < 32; i++)
          if (m_pend[i] && !m_mask[i] && (m_steer[i] == p[0]) && m_prio[i] <= best) begin
            best = m_prio[i]; w = i; any = 1;
          end
        if (wr_en && a == 24 && wdata[p]) begin m_out[p] = 0; m_agr[p] = 1; end
        else if (m_agr[p] && any) begin m_out[p] = 1; m_agr[p] = 0; m_code[p] = w; end
      end
      if (wr_en && a == 4) m_mask = wdata;
      if (wr_en && a % 4 == 0 && a >= 28 && a < 156) begin
        m_prio[(a-28)/4]  = int'(wdata[6:2]);
        m_lvl[(a-28)/4]   = wdata[1];
        m_steer[(a-28)/4] = wdata[0];
      end
      m_rd   = rd_en ? rv : 0;
      m_pend = np;
      m_in   = req_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(irq_o == m_out[0], "R7 irq_o vs model", 32'(irq_o), 32'(m_out[0]));
    chk(fiq_o == m_out[1], "R7 fiq_o vs model", 32'(fiq_o), 32'(m_out[1]));
    chk(rdata == m_rd, "R11 rdata vs model", rdata, m_rd);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0; addr = 0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1;
        idle(1);
        chk(irq_o == 0 && fiq_o == 0, "R1 outputs low", {30'b0, fiq_o, irq_o}, 0);
        rd(8'h04, 32'hFFFF_FFFF, "R1 mask all ones (R11 latency)");
        rd(8'h00, 0, "R1 nothing pending");
        rd(8'h30, 0, "R1 line 5 config zero");

        // edge line 3
        wr(8'h04, 0);
        req_in[3] = 1; idle(4);
        req_in[3] = 0; idle(2);
        rd(8'h00, 32'h8, "R2 edge line held after input fell");
        rd(8'h10, 3, "R8 irq code is line 3");
        rd(8'h00, 0, "R8 edge line acknowledged by code read");
        chk(irq_o == 1, "R7 irq stays high until rearm", 32'(irq_o), 1);
        req_in[3] = 1; idle(3);
        rd(8'h00, 32'h8, "R2 new rising edge pends again");
        wr(8'h18, 1);
        chk(irq_o == 0, "R7 rearm drops irq", 32'(irq_o), 0);
        idle(1);
        chk(irq_o == 1, "R7 irq refires next cycle", 32'(irq_o), 1);
        rd(8'h10, 3, "R8 code after refire");
        wr(8'h18, 1); idle(2);
        chk(irq_o == 0, "R7 no candidate stays low", 32'(irq_o), 0);
        req_in[3] = 0; idle(2);

        // level line 7
        wr(8'h38, 32'h2);
        req_in[7] = 1; idle(3);
        rd(8'h00, 32'h80, "R3 level line pending");
        wr(8'h00, 0);
        rd(8'h00, 32'h80, "R4 level line kept by pending write");
        rd(8'h10, 7, "R8 irq code is line 7");
        rd(8'h00, 32'h80, "R8 level line not acknowledged");
        req_in[7] = 0; idle(2);
        rd(8'h00, 0, "R3 level pending cleared on fall");
        wr(8'h18, 1); idle(2);
        wr(8'h38, 0);

        // priorities: line2 p3, line9 p1, line12 p1
        wr(8'h24, 32'hC); wr(8'h40, 32'h4); wr(8'h4C, 32'h4);
        req_in = 32'h0000_1204; idle(4);
        rd(8'h10, 12, "R6 tie goes to higher line");
        wr(8'h18, 1); idle(3);
        rd(8'h10, 9, "R6 priority 1 before 3");
        wr(8'h18, 1); idle(3);
        rd(8'h10, 2, "R6 last remaining line");
        wr(8'h18, 1); idle(3);
        chk(irq_o == 0, "R6 nothing left", 32'(irq_o), 0);
        req_in = 0; idle(2);

        // fast path on line 20
        wr(8'h6C, 32'h1);
        req_in[20] = 1; idle(4);
        chk(fiq_o == 1, "R6 steered line raises fiq", 32'(fiq_o), 1);
        chk(irq_o == 0, "R6 steered line leaves irq", 32'(irq_o), 0);
        rd(8'h14, 20, "R8 fiq code is line 20");
        wr(8'h18, 2); idle(2);
        chk(fiq_o == 0, "R7 fiq rearm", 32'(fiq_o), 0);
        req_in = 0; idle(2);

        // software trigger
        wr(8'h9C, 32'h300); idle(3);
        rd(8'h00, 32'h100, "R9 only lowest bit triggered");
        chk(irq_o == 1, "R9 trigger raises irq", 32'(irq_o), 1);
        rd(8'h10, 8, "R9 code of triggered line");
        wr(8'h18, 1); idle(2);

        // masking
        wr(8'h04, 32'hFFFF_FFFF);
        req_in[4] = 1; idle(5);
        chk(irq_o == 0, "R10 masked line quiet", 32'(irq_o), 0);
        rd(8'h00, 32'h10, "R10 masked line still pending");
        wr(8'h04, 0);
        chk(irq_o == 0, "R10 unmask not yet seen", 32'(irq_o), 0);
        idle(1);
        chk(irq_o == 1, "R10 unmask effective next cycle", 32'(irq_o), 1);
        rd(8'h10, 4, "R10 code line 4");
        wr(8'h18, 1); req_in = 0; idle(2);

        // access rules
        wr(8'h05, 32'hFFFF_FFFF);
        rd(8'h04, 0, "R5 misaligned write ignored");
        rd(8'h06, 0, "R5 misaligned read returns zero");
        wr(8'h98, 32'hFFFF_FFFF);
        rd(8'h98, 32'h7F, "R5 line 31 config fields only");
        rd(8'h40, 32'h4, "R5 line 9 config readback");
        wr(8'h98, 0);
        idle(4);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule